// File: doc/BRIEF.md
# Zoned Address Decoder and Checker

This block turns a three-character decimal storage address into a binary position index. Each character is eight bits: a four-bit digit code, two zone bits, a check bit and a word-mark bit. The zone bits above the hundreds character and above the units character carry weights of one, two, four and eight thousand. Their sum selects a thousand-block, and the three digits give the offset within that block. Any address from 0 to 15999 can be expressed this way.

On each strobe the block also checks the access. It flags characters with even parity and digit codes that are not decimal. It flags addresses at or beyond the installed capacity. That fault is reported on one of two flags, chosen by whether the address came from an index modification. It also flags a plus-one or minus-one step that would run off either end of storage, except in the modes where running off the end is allowed. The decoded address and a valid pulse appear one clock after the strobe. Every error flag stays set until software clears it.

Top module: `zad_decoder`

## Requirements
- R1: The address is 1000 times the block value plus 100 times the hundreds digit, plus 10 times the tens digit, plus the units digit. The block value adds these weights: 1 for the hundreds A zone bit (bit 4), 2 for the hundreds B zone bit (bit 5), 4 for the units A zone bit and 8 for the units B zone bit. The zone bits of the tens character have no effect.
- R2: Digit codes 0 and 10 (bits 3:0) both count as zero. Codes 1 to 9 count as their own values.
- R3: Each character must have an odd number of set bits over all eight bits, including the check bit (bit 6) and the word mark (bit 7). If any of the three characters has an even count, err_parity is set.
- R4: A digit code from 11 to 15 in any character sets err_digit. Such a digit counts as zero in the address.
- R5: The capacity is chosen by cap_sel: 0 gives 1400, 1 gives 2000, 2 gives 4000, 3 gives 8000, 4 gives 12000, and 5 to 7 give 16000. If index_mod is low, an address at or above the capacity sets err_range.
- R6: If index_mod is high, an address at or above the capacity sets err_index instead of err_range.
- R7: With step_dir = 2'b10 (minus one) and an address of 0, err_wrap is set unless clear_mode is high.
- R8: With step_dir = 2'b01 (plus one) and an address equal to the capacity minus one, err_wrap is set unless scan_mode is high. Step codes 2'b00 and 2'b11 never set err_wrap.
- R9: addr_out and addr_valid are updated on the clock edge that samples addr_stb. addr_valid is high for exactly that one cycle. addr_out holds its value until the next strobe. Reset clears all outputs.
- R10: The error flags are sticky. err_clr alone clears all of them. err_clr in the same cycle as a strobe clears the old flags and keeps only the errors of that strobe. Without a strobe, no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_stb | input | 1 | Address characters and controls are valid |
| hund_char | input | 8 | Hundreds character |
| tens_char | input | 8 | Tens character |
| units_char | input | 8 | Units character |
| cap_sel | input | 3 | Installed capacity code |
| index_mod | input | 1 | Address comes from an index modification |
| step_dir | input | 2 | Step direction: 01 plus one, 10 minus one |
| clear_mode | input | 1 | Clear operation active (allows minus one at 0) |
| scan_mode | input | 1 | Scan or print-out active (allows plus one at top) |
| err_clr | input | 1 | Clear the sticky error flags |
| addr_out | output | 14 | Decoded binary address |
| addr_valid | output | 1 | One-cycle pulse for a new address |
| err_parity | output | 1 | Sticky parity error |
| err_digit | output | 1 | Sticky invalid digit error |
| err_range | output | 1 | Sticky capacity error |
| err_index | output | 1 | Sticky capacity error from an index modification |
| err_wrap | output | 1 | Sticky end-around error |

## Verification
The clear of the sticky flags can fall in the same clock as a new strobe that raises errors of its own. The bench provokes this on purpose, with err_clr and a faulty strobe in the same cycle, after a flag has been left set by an earlier access. The correct result keeps only the new errors and drops every flag carried from before. A behavioural model follows every random cycle, so clears that overlap strobes are judged continuously as well as in the directed case.

// File: rtl/zad_pkg.sv
package zad_pkg;

    localparam int CHAR_W  = 8;
    localparam int DIG_W   = 4;
    localparam int ADDR_W  = 14;
    localparam int CAP_W   = 3;
    localparam int NCHAR   = 3;

    typedef struct packed {
        logic             wm;
        logic             chk;
        logic             zb;
        logic             za;
        logic [DIG_W-1:0] dig;
    } zchar_t;

    typedef struct packed {
        logic parity;
        logic digit;
        logic range;
        logic index;
        logic wrap;
    } zerr_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_RSVD = 2'b11
    } step_t;

    function automatic logic [ADDR_W-1:0] cap_limit(input logic [CAP_W-1:0] sel);
        logic [ADDR_W-1:0] lim;
        case (sel)
            3'd0:    lim = ADDR_W'(1400);
            3'd1:    lim = ADDR_W'(2000);
            3'd2:    lim = ADDR_W'(4000);
            3'd3:    lim = ADDR_W'(8000);
            3'd4:    lim = ADDR_W'(12000);
            default: lim = ADDR_W'(16000);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/zad_char_check.sv
module zad_char_check
    import zad_pkg::*;
#(
    parameter int CW = CHAR_W,
    parameter int DW = DIG_W
) (
    input  logic [CW-1:0] ch,
    output logic [DW-1:0] val,
    output logic          za,
    output logic          zb,
    output logic          par_bad,
    output logic          dig_bad
);
    localparam logic [DW-1:0] ZERO_ALT = DW'(10);
    localparam logic [DW-1:0] NINE     = DW'(9);

    zchar_t c;
    assign c = zchar_t'(ch);

    always_comb begin
        za      = c.za;
        zb      = c.zb;
        // odd parity over all bits; an even count is a fault
        par_bad = ~(^ch);
        dig_bad = 1'b0;
        if (c.dig <= NINE) begin
            val = c.dig;
        end else if (c.dig == ZERO_ALT) begin
            val = '0;
        end else begin
            val     = '0;
            dig_bad = 1'b1;
        end
    end

endmodule

// File: rtl/zad_limit_check.sv
module zad_limit_check
    import zad_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cap,
    input  logic [1:0]    step_dir,
    input  logic          index_mod,
    input  logic          clear_mode,
    input  logic          scan_mode,
    output logic          range_bad,
    output logic          index_bad,
    output logic          wrap_bad
);
    logic over;
    logic at_top;
    logic at_bottom;

    always_comb begin
        over      = (addr >= cap);
        at_top    = (addr == cap - AW'(1));
        at_bottom = (addr == '0);
        range_bad = over & ~index_mod;
        index_bad = over &  index_mod;
        case (step_t'(step_dir))
            STEP_INC: wrap_bad = at_top & ~scan_mode;
            STEP_DEC: wrap_bad = at_bottom & ~clear_mode;
            default:  wrap_bad = 1'b0;
        endcase
    end

endmodule

// File: rtl/zad_decoder.sv
module zad_decoder
    import zad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_stb,
    input  logic [CHAR_W-1:0] hund_char,
    input  logic [CHAR_W-1:0] tens_char,
    input  logic [CHAR_W-1:0] units_char,
    input  logic [CAP_W-1:0]  cap_sel,
    input  logic              index_mod,
    input  logic [1:0]        step_dir,
    input  logic              clear_mode,
    input  logic              scan_mode,
    input  logic              err_clr,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid,
    output logic              err_parity,
    output logic              err_digit,
    output logic              err_range,
    output logic              err_index,
    output logic              err_wrap
);
    localparam int HUND = 2;
    localparam int TENS = 1;
    localparam int UNIT = 0;
    localparam logic [ADDR_W-1:0] K_THOU = ADDR_W'(1000);
    localparam logic [ADDR_W-1:0] K_HUND = ADDR_W'(100);
    localparam logic [ADDR_W-1:0] K_TEN  = ADDR_W'(10);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              vld;
        zerr_t             err;
    } state_t;

    logic [CHAR_W-1:0] chars  [NCHAR];
    logic [DIG_W-1:0]  dval   [NCHAR];
    logic [NCHAR-1:0]  za_v, zb_v, par_v, dig_v;

    assign chars[HUND] = hund_char;
    assign chars[TENS] = tens_char;
    assign chars[UNIT] = units_char;

    for (genvar i = 0; i < NCHAR; i++) begin : g_char
        zad_char_check #(.CW(CHAR_W), .DW(DIG_W)) u_chk (
            .ch      (chars[i]),
            .val     (dval[i]),
            .za      (za_v[i]),
            .zb      (zb_v[i]),
            .par_bad (par_v[i]),
            .dig_bad (dig_v[i])
        );
    end

    logic [3:0]        blk;
    logic [ADDR_W-1:0] addr_dec;
    logic [ADDR_W-1:0] cap;
    logic              range_bad, index_bad, wrap_bad;

    always_comb begin
        // weights 8,4,2,1 = units B, units A, hundreds B, hundreds A
        blk      = {zb_v[UNIT], za_v[UNIT], zb_v[HUND], za_v[HUND]};
        addr_dec = ADDR_W'(blk) * K_THOU
                 + ADDR_W'(dval[HUND]) * K_HUND
                 + ADDR_W'(dval[TENS]) * K_TEN
                 + ADDR_W'(dval[UNIT]);
        cap      = cap_limit(cap_sel);
    end

    zad_limit_check #(.AW(ADDR_W)) u_lim (
        .addr       (addr_dec),
        .cap        (cap),
        .step_dir   (step_dir),
        .index_mod  (index_mod),
        .clear_mode (clear_mode),
        .scan_mode  (scan_mode),
        .range_bad  (range_bad),
        .index_bad  (index_bad),
        .wrap_bad   (wrap_bad)
    );

    state_t st_d, st_q;
    zerr_t  new_err;
    zerr_t  kept_err;

    always_comb begin
        new_err.parity = |par_v;
        new_err.digit  = |dig_v;
        new_err.range  = range_bad;
        new_err.index  = index_bad;
        new_err.wrap   = wrap_bad;
        kept_err       = err_clr ? '0 : st_q.err;

        st_d     = st_q;
        st_d.vld = addr_stb;
        st_d.err = kept_err;
        if (addr_stb) begin
            st_d.addr = addr_dec;
            st_d.err  = kept_err | new_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out   = st_q.addr;
    assign addr_valid = st_q.vld;
    assign err_parity = st_q.err.parity;
    assign err_digit  = st_q.err.digit;
    assign err_range  = st_q.err.range;
    assign err_index  = st_q.err.index;
    assign err_wrap   = st_q.err.wrap;

endmodule

// File: rtl/zad_decoder_chk.sv
module zad_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_stb,
    input logic        index_mod,
    input logic [1:0]  step_dir,
    input logic        err_clr,
    input logic [13:0] addr_out,
    input logic        addr_valid,
    input logic        err_parity,
    input logic        err_digit,
    input logic        err_range,
    input logic        err_index,
    input logic        err_wrap
);
    logic [4:0] ev;
    assign ev = {err_parity, err_digit, err_range, err_index, err_wrap};

    assert_valid_after_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> addr_valid);

    assert_no_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stb |=> !addr_valid);

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stb |=> $stable(addr_out));

    assert_addr_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (addr_out < 14'd16000));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((ev & $past(ev)) == $past(ev)));

    assert_clear_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !addr_stb) |=> (ev == 5'b0));

    assert_no_set_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stb |=> ($countones(ev) <= $countones($past(ev))));

    // covers R7 and R8: end-around faults only come from a step request
    assert_wrap_needs_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_wrap) |-> $past(addr_stb && (step_dir == 2'b01 || step_dir == 2'b10)));

    assert_index_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_index) |-> $past(addr_stb && index_mod));

    assert_range_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_range) |-> $past(addr_stb && !index_mod));

endmodule

bind zad_decoder zad_decoder_chk u_zad_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_stb   (addr_stb),
    .index_mod  (index_mod),
    .step_dir   (step_dir),
    .err_clr    (err_clr),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .err_parity (err_parity),
    .err_digit  (err_digit),
    .err_range  (err_range),
    .err_index  (err_index),
    .err_wrap   (err_wrap)
);

// File: tb/zad_decoder_test.sv
module zad_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_stb = 1'b0;
    logic [7:0]  hund_char = 8'h00, tens_char = 8'h00, units_char = 8'h00;
    logic [2:0]  cap_sel = 3'd5;
    logic        index_mod = 1'b0;
    logic [1:0]  step_dir = 2'b00;
    logic        clear_mode = 1'b0, scan_mode = 1'b0, err_clr = 1'b0;
    logic [13:0] addr_out;
    logic        addr_valid, err_parity, err_digit, err_range, err_index, err_wrap;

    always #4 clk = ~clk;

    zad_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb),
        .hund_char(hund_char), .tens_char(tens_char), .units_char(units_char),
        .cap_sel(cap_sel), .index_mod(index_mod), .step_dir(step_dir),
        .clear_mode(clear_mode), .scan_mode(scan_mode), .err_clr(err_clr),
        .addr_out(addr_out), .addr_valid(addr_valid), .err_parity(err_parity),
        .err_digit(err_digit), .err_range(err_range), .err_index(err_index),
        .err_wrap(err_wrap)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit cmp_on = 0;

    int m_addr = 0;
    bit m_vld = 0, m_par = 0, m_dig = 0, m_rng = 0, m_idx = 0, m_wrp = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [7:0] mkc(input int zone, input int code, input bit wm, input bit badpar);
        logic [7:0] c;
        c = {wm, 1'b0, zone[1], zone[0], code[3:0]};
        if (^c == 1'b0) c[6] = 1'b1;
        if (badpar) c[6] = ~c[6];
        return c;
    endfunction

    function automatic int dig_of(input logic [3:0] code);
        if (code >= 1 && code <= 9) return int'(code);
        return 0;
    endfunction

    function automatic int cap_of(input logic [2:0] s);
        int caps[8] = '{1400, 2000, 4000, 8000, 12000, 16000, 16000, 16000};
        return caps[s];
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        int blk, a, cap;
        bit p, d, ov, w;
        if (!rst_n) begin
            m_addr <= 0; m_vld <= 0;
            m_par <= 0; m_dig <= 0; m_rng <= 0; m_idx <= 0; m_wrp <= 0;
        end else begin
            m_vld <= addr_stb;
            if (addr_stb) begin
                blk = (hund_char[4] ? 1 : 0) + (hund_char[5] ? 2 : 0)
                    + (units_char[4] ? 4 : 0) + (units_char[5] ? 8 : 0);
                a = blk * 1000 + dig_of(hund_char[3:0]) * 100
                  + dig_of(tens_char[3:0]) * 10 + dig_of(units_char[3:0]);
                cap = cap_of(cap_sel);
                p = (^hund_char == 1'b0) || (^tens_char == 1'b0) || (^units_char == 1'b0);
                d = (hund_char[3:0] > 10) || (tens_char[3:0] > 10) || (units_char[3:0] > 10);
                ov = (a >= cap);
                w = (step_dir == 2'b01 && a == cap - 1 && !scan_mode)
                 || (step_dir == 2'b10 && a == 0 && !clear_mode);
                m_addr <= a;
                m_par <= (err_clr ? 1'b0 : m_par) | p;
                m_dig <= (err_clr ? 1'b0 : m_dig) | d;
                m_rng <= (err_clr ? 1'b0 : m_rng) | (ov & !index_mod);
                m_idx <= (err_clr ? 1'b0 : m_idx) | (ov & index_mod);
                m_wrp <= (err_clr ? 1'b0 : m_wrp) | w;
            end else if (err_clr) begin
                m_par <= 0; m_dig <= 0; m_rng <= 0; m_idx <= 0; m_wrp <= 0;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1", "addr_out model", int'(addr_out), m_addr);
            chk("R9", "addr_valid model", int'(addr_valid), int'(m_vld));
            chk("R3", "err_parity model", int'(err_parity), int'(m_par));
            chk("R4", "err_digit model", int'(err_digit), int'(m_dig));
            chk("R5", "err_range model", int'(err_range), int'(m_rng));
            chk("R6", "err_index model", int'(err_index), int'(m_idx));
            chk("R8", "err_wrap model", int'(err_wrap), int'(m_wrp));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL R9 watchdog actual=timeout expected=done");
            summary();
        end
    end

    task automatic send(input logic [7:0] h, input logic [7:0] t, input logic [7:0] u,
                        input logic [2:0] cs, input bit idx, input logic [1:0] st,
                        input bit cm, input bit sm, input bit clr);
        @(negedge clk);
        hund_char = h; tens_char = t; units_char = u;
        cap_sel = cs; index_mod = idx; step_dir = st;
        clear_mode = cm; scan_mode = sm; err_clr = clr; addr_stb = 1'b1;
        @(negedge clk);
        addr_stb = 1'b0; err_clr = 1'b0;
    endtask

    task automatic flags(input string req, input int p, input int d, input int r, input int i, input int w);
        chk(req, "err_parity", int'(err_parity), p);
        chk(req, "err_digit", int'(err_digit), d);
        chk(req, "err_range", int'(err_range), r);
        chk(req, "err_index", int'(err_index), i);
        chk(req, "err_wrap", int'(err_wrap), w);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "reset addr_out", int'(addr_out), 0);
        chk("R9", "reset addr_valid", int'(addr_valid), 0);
        flags("R10", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1;

        // R1 R2: B over hundreds, A over units, tens code 10 -> 6507
        send(mkc(2, 5, 0, 0), mkc(0, 10, 0, 0), mkc(1, 7, 0, 0), 3'd3, 0, 2'b00, 0, 0, 1);
        chk("R1", "zoned decode", int'(addr_out), 6507);
        chk("R9", "valid pulse", int'(addr_valid), 1);
        flags("R1", 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R9", "valid drops", int'(addr_valid), 0);
        chk("R9", "addr holds", int'(addr_out), 6507);
        // R1: tens zone bits ignored, word mark allowed
        send(mkc(2, 5, 0, 0), mkc(3, 10, 1, 0), mkc(1, 7, 1, 0), 3'd3, 0, 2'b00, 0, 0, 1);
        chk("R1", "tens zone ignored", int'(addr_out), 6507);
        flags("R3", 0, 0, 0, 0, 0);
        // R2: blank code 0 as zero
        send(mkc(0, 0, 0, 0), mkc(0, 4, 0, 0), mkc(0, 0, 0, 0), 3'd5, 0, 2'b00, 0, 0, 1);
        chk("R2", "blank digits", int'(addr_out), 40);
        // R3 bad parity on tens
        send(mkc(0, 1, 0, 0), mkc(0, 2, 1, 1), mkc(0, 3, 0, 0), 3'd5, 0, 2'b00, 0, 0, 1);
        flags("R3", 1, 0, 0, 0, 0);
        // R4 digit code 12
        send(mkc(0, 1, 0, 0), mkc(0, 2, 0, 0), mkc(0, 12, 0, 0), 3'd5, 0, 2'b00, 0, 0, 1);
        flags("R4", 0, 1, 0, 0, 0);
        chk("R4", "bad digit as zero", int'(addr_out), 120);
        // R5 capacity 1400
        send(mkc(1, 4, 0, 0), mkc(0, 10, 0, 0), mkc(0, 10, 0, 0), 3'd0, 0, 2'b00, 0, 0, 1);
        chk("R5", "addr 1400", int'(addr_out), 1400);
        flags("R5", 0, 0, 1, 0, 0);
        send(mkc(1, 3, 0, 0), mkc(0, 9, 0, 0), mkc(0, 9, 0, 0), 3'd0, 0, 2'b00, 0, 0, 1);
        flags("R5", 0, 0, 0, 0, 0);
        // R6 index route
        send(mkc(1, 4, 0, 0), mkc(0, 10, 0, 0), mkc(0, 10, 0, 0), 3'd0, 1, 2'b00, 0, 0, 1);
        flags("R6", 0, 0, 0, 1, 0);
        // R7 minus one at 0
        send(mkc(0, 10, 0, 0), mkc(0, 10, 0, 0), mkc(0, 10, 0, 0), 3'd5, 0, 2'b10, 1, 0, 1);
        flags("R7", 0, 0, 0, 0, 0);
        send(mkc(0, 10, 0, 0), mkc(0, 10, 0, 0), mkc(0, 10, 0, 0), 3'd5, 0, 2'b10, 0, 0, 1);
        flags("R7", 0, 0, 0, 0, 1);
        // R8 plus one at top
        send(mkc(3, 9, 0, 0), mkc(0, 9, 0, 0), mkc(3, 9, 0, 0), 3'd5, 0, 2'b01, 0, 0, 1);
        chk("R8", "addr 15999", int'(addr_out), 15999);
        flags("R8", 0, 0, 0, 0, 1);
        send(mkc(3, 9, 0, 0), mkc(0, 9, 0, 0), mkc(3, 9, 0, 0), 3'd5, 0, 2'b01, 0, 1, 1);
        flags("R8", 0, 0, 0, 0, 0);
        send(mkc(1, 9, 0, 0), mkc(0, 9, 0, 0), mkc(0, 9, 0, 0), 3'd1, 0, 2'b01, 0, 0, 1);
        flags("R8", 0, 0, 0, 0, 1);
        send(mkc(1, 9, 0, 0), mkc(0, 9, 0, 0), mkc(0, 9, 0, 0), 3'd1, 0, 2'b11, 0, 0, 1);
        flags("R8", 0, 0, 0, 0, 0);
        // R10 sticky, clear alone, clear with strobe
        send(mkc(0, 1, 0, 1), mkc(0, 1, 0, 0), mkc(0, 1, 0, 0), 3'd5, 0, 2'b00, 0, 0, 0);
        send(mkc(0, 1, 0, 0), mkc(0, 1, 0, 0), mkc(0, 1, 0, 0), 3'd5, 0, 2'b00, 0, 0, 0);
        flags("R10", 1, 0, 0, 0, 0);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        flags("R10", 0, 0, 0, 0, 0);
        send(mkc(0, 1, 0, 1), mkc(0, 1, 0, 0), mkc(0, 1, 0, 0), 3'd5, 0, 2'b00, 0, 0, 0);
        send(mkc(0, 1, 0, 0), mkc(0, 13, 0, 0), mkc(0, 1, 0, 0), 3'd5, 0, 2'b00, 0, 0, 1);
        flags("R10", 0, 1, 0, 0, 0);

        // random phase, model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            hund_char  = mkc(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                             bit'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0));
            tens_char  = mkc(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                             bit'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0));
            units_char = mkc(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                             bit'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0));
            cap_sel    = 3'($urandom_range(0, 7));
            index_mod  = bit'($urandom_range(0, 1));
            step_dir   = 2'($urandom_range(0, 3));
            clear_mode = bit'($urandom_range(0, 1));
            scan_mode  = bit'($urandom_range(0, 1));
            err_clr    = ($urandom_range(0, 7) == 0);
            addr_stb   = ($urandom_range(0, 9) < 7);
        end
        @(negedge clk);
        addr_stb = 1'b0; err_clr = 1'b0;
        repeat (2) @(negedge clk);
        summary();
    end

endmodule